// File: doc/BRIEF.md
# Storage Row Sequencer with Row Clock

This block walks the rows of a 1200-row message store while a record, playback or message-cueing operation runs. A sample tick comes from one of four internal rates or from an external clock divided by two. That tick sets the pace of each row. Every row is split into eight equal segments. The row-clock output is pulled low only during the last segment of each row, so it is high for seven eighths of the row and low for the final eighth. The row-clock output is open-drain and is modelled as a pull-low enable. When a record operation begins, the first row is preceded by one extra high segment, which gives the sampling stages time to settle. In cueing mode each segment is a short, fixed number of system clocks, so the store can be skimmed quickly.

A start pulse latches the operation mode and loads a start row. The row address then advances by one at the end of each row. Completing the final row produces a one-cycle overflow pulse and halts the sequencer. During playback, an eight-bit marker vector names the segments of the current row that hold an end-of-message mark. Reaching the end of a marked segment produces a one-cycle end-of-message pulse and halts the sequencer. A stop input halts the sequencer at any time, and the row address stays readable.

Top module: `rac_row_seq`

## Requirements
- R1: Out of reset the row address is 0, the sequencer is idle, the row-clock pull-low is released, and neither event pulse is high.
- R2: A start pulse loads the start row, clamped to ROWS-1 (1199), latches the mode and makes the sequencer busy from the next cycle.
- R3: Outside cueing mode a row lasts 1600 sample ticks (8 segments of 200 ticks), and the row address then increments by one.
- R4: rate_sel_i picks the clocks per sample tick: 00 gives DIV0 (8.0 kHz), 01 gives DIV1 (6.4 kHz), 10 gives DIV2 (5.3 kHz) and 11 gives DIV3 (4.0 kHz). The row clock is pulled low only in segment 7, the last 200 ticks of a row, and only while busy.
- R5: With ext_sel_i high, one sample tick is produced for every two rising edges of ext_clk_i, and rate_sel_i has no effect.
- R6: Mode encoding: 00 is playback, 01 is record, and 10 or 11 is cueing. In record mode the first row after a start carries one extra 200-tick segment with the row clock released. Later rows are normal.
- R7: In cueing mode a segment is CUE_SEG system clocks, so a row is 8*CUE_SEG clocks and the row clock is low for the last CUE_SEG clocks.
- R8: Completing row ROWS-1 raises ovf_o for exactly one cycle and halts the sequencer. The row address stays at ROWS-1.
- R9: In playback, if bit k of eom_mark_i is set, eom_o pulses for one cycle at the end of segment k (bit 0 is the first segment) and the sequencer halts. The row address does not advance, and overflow is suppressed on that edge.
- R10: Marker bits are ignored in record and cueing modes: no end-of-message pulse, and rows advance normally.
- R11: stop_i halts the sequencer on the next edge, holds the row address and releases the row clock. When start_i and stop_i are high together, stop wins and nothing is loaded.
- R12: The row address changes only by a load or by an increment of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse: load row, latch mode |
| stop_i | input | 1 | Halt the sequencer |
| mode_i | input | 2 | Operation mode (00 play, 01 record, 1x cue) |
| start_row_i | input | AW (11) | Row loaded on start |
| rate_sel_i | input | 2 | Internal sample-rate select |
| ext_sel_i | input | 1 | Use external clock for sample ticks |
| ext_clk_i | input | 1 | External clock, divided by two internally |
| eom_mark_i | input | 8 | End-of-message marks, one per segment of the current row |
| row_o | output | AW (11) | Current row address |
| rac_pull_o | output | 1 | Row-clock pull-low enable |
| busy_o | output | 1 | Sequencer running |
| ovf_o | output | 1 | One-cycle overflow pulse |
| eom_o | output | 1 | One-cycle end-of-message pulse |

## Verification
The bound checker watches, on every cycle, the shape of the two event pulses, the row address at overflow, that the address only steps by one between loads, that end-of-message comes only from a playback operation, and that the row clock and stop behave consistently with busy. Exact row lengths and row-clock low windows need long runs, and so do the rate and external-clock scaling, the extra record segment, marker positions and precedence, and the clamp of the start row. Only the bench's timed scenarios can show these, by counting clocks between address changes.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  localparam int unsigned SEGS = 8;

  typedef enum logic [1:0] {
    OP_PLAY    = 2'b00,
    OP_REC     = 2'b01,
    OP_CUE     = 2'b10,
    OP_CUE_ALT = 2'b11
  } op_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rseq_tick_gen.sv
module rseq_tick_gen import rseq_pkg::*; #(
  parameter int unsigned DIV0 = 4,
  parameter int unsigned DIV1 = 5,
  parameter int unsigned DIV2 = 6,
  parameter int unsigned DIV3 = 8,
  localparam int unsigned CW = $clog2(umax(umax(DIV0, DIV1), umax(DIV2, DIV3))) + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic [1:0] rate_sel_i,
  input  logic       ext_sel_i,
  input  logic       ext_clk_i,
  output logic       tick_o
);
  localparam int unsigned DIVS [4] = '{DIV0, DIV1, DIV2, DIV3};

  logic [CW-1:0] lim [4];
  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim[g] = CW'(DIVS[g] - 1);
  end

  logic [CW-1:0] cnt_q;
  logic          ext_q, half_q;
  logic          rise, int_hit;

  assign rise    = ext_clk_i & ~ext_q;
  assign int_hit = (cnt_q >= lim[rate_sel_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ext_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      ext_q <= ext_clk_i;
      if (clr_i || !run_i)   cnt_q <= '0;
      else if (!ext_sel_i)   cnt_q <= int_hit ? '0 : cnt_q + 1'b1;
      // external path: every second rising edge is a tick
      if (clr_i)                            half_q <= 1'b0;
      else if (run_i && ext_sel_i && rise)  half_q <= ~half_q;
    end
  end

  assign tick_o = run_i && (ext_sel_i ? (rise && half_q) : int_hit);
endmodule

// File: rtl/rseq_row_timer.sv
module rseq_row_timer import rseq_pkg::*; #(
  parameter int unsigned SEG_TICKS = 200,
  parameter int unsigned CUE_SEG   = 4,
  localparam int unsigned TW = $clog2(umax(SEG_TICKS, CUE_SEG)) + 1,
  localparam int unsigned IW = $clog2(SEGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          pre_i,
  input  logic          run_i,
  input  logic          step_i,
  input  logic          cue_i,
  output logic [IW-1:0] seg_idx_o,
  output logic          seg_end_o,
  output logic          row_end_o,
  output logic          rac_pull_o
);
  logic [TW-1:0] cnt_q, seg_lim;
  logic [IW-1:0] idx_q;
  logic          pre_q, seg_done;

  assign seg_lim  = cue_i ? TW'(CUE_SEG - 1) : TW'(SEG_TICKS - 1);
  assign seg_done = step_i && (cnt_q >= seg_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
      pre_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      idx_q <= '0;
      pre_q <= pre_i;
    end else if (run_i && step_i) begin
      if (cnt_q >= seg_lim) begin
        cnt_q <= '0;
        if (pre_q) pre_q <= 1'b0;        // extra settle segment consumed
        else       idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign seg_idx_o  = idx_q;
  assign seg_end_o  = run_i && seg_done && !pre_q;
  assign row_end_o  = seg_end_o && (idx_q == IW'(SEGS - 1));
  assign rac_pull_o = run_i && !pre_q && (idx_q == IW'(SEGS - 1));
endmodule

// File: rtl/rseq_row_track.sv
module rseq_row_track #(
  parameter int unsigned ROWS = 1200,
  localparam int unsigned AW = $clog2(ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] start_row_i,
  input  logic          row_end_i,
  input  logic          eom_hit_i,
  output logic [AW-1:0] row_o,
  output logic          ovf_o,
  output logic          eom_o,
  output logic          halt_o
);
  localparam logic [AW-1:0] LAST = AW'(ROWS - 1);

  logic [AW-1:0] row_q;
  logic          ovf_q, eom_q, at_last, ovf_evt;

  assign at_last = (row_q == LAST);
  assign ovf_evt = row_end_i && at_last && !eom_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      ovf_q <= 1'b0;
      eom_q <= 1'b0;
    end else begin
      if (load_i)
        row_q <= (start_row_i > LAST) ? LAST : start_row_i;
      else if (row_end_i && !at_last && !eom_hit_i)
        row_q <= row_q + 1'b1;
      ovf_q <= ovf_evt;
      eom_q <= eom_hit_i;
    end
  end

  assign row_o  = row_q;
  assign ovf_o  = ovf_q;
  assign eom_o  = eom_q;
  assign halt_o = ovf_evt | eom_hit_i;
endmodule

// File: rtl/rac_row_seq.sv
module rac_row_seq import rseq_pkg::*; #(
  parameter int unsigned ROWS      = 1200,
  parameter int unsigned SEG_TICKS = 200,
  parameter int unsigned CUE_SEG   = 4,
  parameter int unsigned DIV0      = 4,
  parameter int unsigned DIV1      = 5,
  parameter int unsigned DIV2      = 6,
  parameter int unsigned DIV3      = 8,
  localparam int unsigned AW = $clog2(ROWS),
  localparam int unsigned IW = $clog2(SEGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [1:0]      mode_i,
  input  logic [AW-1:0]   start_row_i,
  input  logic [1:0]      rate_sel_i,
  input  logic            ext_sel_i,
  input  logic            ext_clk_i,
  input  logic [SEGS-1:0] eom_mark_i,
  output logic [AW-1:0]   row_o,
  output logic            rac_pull_o,
  output logic            busy_o,
  output logic            ovf_o,
  output logic            eom_o
);
  op_e           op_q;
  logic          run_q, start_evt, halt, cue, play;
  logic          tick, step, seg_end, row_end, eom_hit;
  logic [IW-1:0] seg_idx;

  assign start_evt = start_i && !stop_i;
  assign cue       = op_q[1];
  assign play      = (op_q == OP_PLAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      op_q  <= OP_PLAY;
    end else if (start_evt) begin
      run_q <= 1'b1;
      op_q  <= op_e'(mode_i);
    end else if (stop_i || halt) begin
      run_q <= 1'b0;
    end
  end

  rseq_tick_gen #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) u_tick (
    .clk_i, .rst_ni,
    .clr_i      (start_evt),
    .run_i      (run_q),
    .rate_sel_i,
    .ext_sel_i,
    .ext_clk_i,
    .tick_o     (tick)
  );

  assign step = cue ? 1'b1 : tick;

  rseq_row_timer #(.SEG_TICKS(SEG_TICKS), .CUE_SEG(CUE_SEG)) u_timer (
    .clk_i, .rst_ni,
    .restart_i  (start_evt),
    .pre_i      (mode_i == OP_REC),
    .run_i      (run_q),
    .step_i     (step),
    .cue_i      (cue),
    .seg_idx_o  (seg_idx),
    .seg_end_o  (seg_end),
    .row_end_o  (row_end),
    .rac_pull_o (rac_pull_o)
  );

  assign eom_hit = seg_end && play && eom_mark_i[seg_idx];

  rseq_row_track #(.ROWS(ROWS)) u_track (
    .clk_i, .rst_ni,
    .load_i      (start_evt),
    .start_row_i,
    .row_end_i   (row_end),
    .eom_hit_i   (eom_hit),
    .row_o,
    .ovf_o,
    .eom_o,
    .halt_o      (halt)
  );

  assign busy_o = run_q;
endmodule

// File: rtl/rac_row_seq_chk.sv
module rac_row_seq_chk #(
  parameter int unsigned ROWS = 1200,
  localparam int unsigned AW = $clog2(ROWS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic [AW-1:0] row_o,
  input logic          rac_pull_o,
  input logic          busy_o,
  input logic          ovf_o,
  input logic          eom_o,
  input logic [1:0]    op_i
);
  a_r8_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !$past(start_i) |=> !ovf_o);

  a_r8_ovf_last_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (row_o == AW'(ROWS - 1)) && !busy_o);

  a_r9_eom_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_o && !$past(start_i) |=> !eom_o);

  a_r10_eom_play_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eom_o |-> $past(op_i) == 2'b00);

  a_r12_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_o != $past(row_o)) && !$past(start_i) |-> row_o == AW'($past(row_o) + 1'b1));

  a_r4_rac_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rac_pull_o |-> busy_o);

  a_r11_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> !busy_o);

  a_r2_row_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o <= AW'(ROWS - 1));
endmodule

bind rac_row_seq rac_row_seq_chk #(.ROWS(ROWS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .row_o      (row_o),
  .rac_pull_o (rac_pull_o),
  .busy_o     (busy_o),
  .ovf_o      (ovf_o),
  .eom_o      (eom_o),
  .op_i       (op_q)
);

// File: tb/sim_rac_row_seq.sv
`timescale 1ns/1ps
module sim_rac_row_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [1:0]  mode_i = 2'b00, rate_sel_i = 2'b00;
  logic [10:0] start_row_i = '0;
  logic        ext_sel_i = 1'b0, ext_clk_i = 1'b0;
  logic [7:0]  eom_mark_i = '0;
  logic [10:0] row_o;
  logic        rac_pull_o, busy_o, ovf_o, eom_o;

  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [1:0] V_RATE [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         V_ROW  [4] = '{6400, 8000, 9600, 12800};
  localparam int         V_LOW  [4] = '{800, 1000, 1200, 1600};

  always #2 clk = ~clk;

  initial forever begin
    repeat (2) @(negedge clk);
    ext_clk_i = ~ext_clk_i;
  end

  rac_row_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .stop_i, .mode_i, .start_row_i,
    .rate_sel_i, .ext_sel_i, .ext_clk_i, .eom_mark_i,
    .row_o, .rac_pull_o, .busy_o, .ovf_o, .eom_o
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] md, input int row, input logic [1:0] rate,
                          input logic ext, input logic [7:0] mask);
    mode_i = md; start_row_i = row[10:0]; rate_sel_i = rate;
    ext_sel_i = ext; eom_mark_i = mask; start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic halt();
    stop_i = 1'b1;
    @(posedge clk); #1 stop_i = 1'b0;
  endtask

  task automatic run_row(input int limit, output int n, output int lows);
    logic [10:0] a0;
    a0 = row_o; n = 0; lows = 0;
    while (row_o == a0 && !ovf_o && !eom_o && n < limit) begin
      if (rac_pull_o) lows++;
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, lows;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check(row_o, 0, "R1 row");
    check(busy_o, 0, "R1 busy");
    check(rac_pull_o, 0, "R1 rac");
    check(ovf_o | eom_o, 0, "R1 events");

    // rate table
    for (int i = 0; i < 4; i++) begin
      start_op(2'b00, 100 + i, V_RATE[i], 1'b0, 8'h00);
      check(row_o, 100 + i, "R2 load");
      check(busy_o, 1, "R2 busy");
      run_row(20000, n, lows);
      check(n, V_ROW[i], "R3 R4 row length");
      check(lows, V_LOW[i], "R4 rac low");
      check(row_o, 101 + i, "R12 increment");
      halt();
    end

    // external clock, /2 after edge detect; rate select ignored
    start_op(2'b00, 10, 2'b11, 1'b1, 8'h00);
    run_row(30000, n, lows);
    check(row_o, 11, "R5 first row");
    run_row(30000, n, lows);
    check(n, 12800, "R5 ext row length");
    check(lows, 1600, "R5 ext rac low");
    halt();
    ext_sel_i = 1'b0;

    // record: extra first segment, markers ignored
    start_op(2'b01, 5, 2'b00, 1'b0, 8'hFF);
    run_row(20000, n, lows);
    check(n, 7200, "R6 first record row");
    check(lows, 800, "R6 rac low");
    check(eom_o, 0, "R10 record eom");
    check(row_o, 6, "R10 record advance");
    run_row(20000, n, lows);
    check(n, 6400, "R6 later record row");
    halt();

    // record overflow
    start_op(2'b01, 1199, 2'b00, 1'b0, 8'h00);
    run_row(20000, n, lows);
    check(n, 7200, "R8 ovf time");
    check(ovf_o, 1, "R8 ovf");
    check(row_o, 1199, "R8 row held");
    check(busy_o, 0, "R8 halted");
    @(posedge clk); #1;
    check(ovf_o, 0, "R8 pulse");

    // cueing
    start_op(2'b10, 30, 2'b00, 1'b0, 8'hFF);
    run_row(1000, n, lows);
    check(n, 32, "R7 cue row");
    check(lows, 4, "R7 cue rac low");
    check(eom_o, 0, "R10 cue eom");
    check(row_o, 31, "R10 cue advance");
    halt();

    // clamp + cue overflow
    start_op(2'b11, 2000, 2'b00, 1'b0, 8'h00);
    check(row_o, 1199, "R2 clamp");
    run_row(1000, n, lows);
    check(n, 32, "R8 cue ovf time");
    check(ovf_o, 1, "R8 cue ovf");
    check(busy_o, 0, "R8 cue halted");

    // end of message in playback
    start_op(2'b00, 20, 2'b00, 1'b0, 8'b0000_0100);
    run_row(20000, n, lows);
    check(n, 2400, "R9 seg2 time");
    check(eom_o, 1, "R9 eom");
    check(row_o, 20, "R9 row held");
    check(busy_o, 0, "R9 halted");
    @(posedge clk); #1;
    check(eom_o, 0, "R9 pulse");
    start_op(2'b00, 21, 2'b00, 1'b0, 8'h01);
    run_row(20000, n, lows);
    check(n, 800, "R9 seg0 time");
    start_op(2'b00, 1199, 2'b00, 1'b0, 8'h80);
    run_row(20000, n, lows);
    check(n, 6400, "R9 seg7 time");
    check(eom_o, 1, "R9 eom last row");
    check(ovf_o, 0, "R9 ovf suppressed");
    check(row_o, 1199, "R9 last row held");

    // stop
    start_op(2'b00, 40, 2'b00, 1'b0, 8'h00);
    repeat (100) @(posedge clk);
    #1 halt();
    check(busy_o, 0, "R11 stop");
    check(rac_pull_o, 0, "R11 rac released");
    repeat (7000) @(posedge clk);
    #1 check(row_o, 40, "R11 row held");
    mode_i = 2'b00; start_row_i = 11'd77;
    start_i = 1'b1; stop_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0; stop_i = 1'b0;
    check(busy_o, 0, "R11 stop wins");
    check(row_o, 40, "R11 no load");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule